// File: doc/BRIEF.md
# Clock-Gated Register-File Memory

This block is a small multi-word memory built from standard storage cells rather than a compiled macro. It has one write port with a per-slice write mask and any number of independent read ports. Each read port returns a word combinationally from its own address. A write is accepted on the rising clock edge. Only the addressed word and the enabled mask slices take a clock pulse. Every other bit is clock-gated and holds its value.

A compile-time parameter picks one of two storage styles. In the edge-triggered style each bit is a register clocked by its slice's gated clock. In the latch style each bit is two positive-enable latches in series. The front latch takes an inverted copy of the slice's gated clock, so it is open while that clock is low. The back latch is open while the gated clock is high. Each word-slice has one inverter that serves all of its bits. Both styles give the same behaviour at the ports.

Every gated clock comes from a latch-based clock gate. Its enable latch is open during the low phase of the clock, so the gated clock is free of glitches.

Top module: `rf_regfile`

## Requirements
- R1: Parameter `STORE_STYLE` selects `STORE_FLOP` (the default) or `STORE_LATCH`. For the same stimulus, both styles give identical read data on every port.
- R2: A write with `wrEn` high and every `wrMask` bit set stores `wrData` into word `wrAddr` at the rising clock edge. A read of that word shows the new value from that edge onward.
- R3: Mask bit s covers data bits [s*SLICE_BITS +: SLICE_BITS]. When mask bit s is 0, that slice of the addressed word keeps its old value. Slices whose mask bit is 1 are written.
- R4: A write changes no word other than the one selected by `wrAddr`.
- R5: While `wrEn` is low, no word changes, whatever `wrAddr`, `wrMask` and `wrData` carry.
- R6: While `rstN` is low, write requests are ignored and the stored contents are left as they were.
- R7: Read port p takes its address from `rdAddr[p*AW +: AW]` and returns data on `rdData[p*WORD_BITS +: WORD_BITS]`. Ports read different words in the same cycle without interfering.
- R8: For each mask slice, at most one word receives a gated clock pulse per cycle. A run of writes to successive addresses leaves each word holding its own value.
- R9: Write data is taken at the rising edge. A change of `wrData` during the high phase that follows does not alter the stored word.
- R10: Reads are combinational. A new read address gives the new word's data without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rstN | input | 1 | Active-low reset; blocks all writes while low |
| wrEn | input | 1 | Write request |
| wrAddr | input | AW | Word address of the write |
| wrMask | input | WORD_BITS/SLICE_BITS | One enable bit per data slice |
| wrData | input | WORD_BITS | Data to store |
| rdAddr | input | READ_PORTS*AW | Concatenated read addresses, port 0 in the low bits |
| rdData | output | READ_PORTS*WORD_BITS | Concatenated read data, port 0 in the low bits |

## Verification
The data-hold properties assume that every word has been written with a full mask before a cycle with `wrEn` low or a partial mask occurs. Until then read data is unknown. The bench meets this by raising `wrEn` before it releases reset and writing every word back to back. The latch style also assumes that write inputs are stable around the rising edge and change only during the low phase, except where the high-phase data change is tested on purpose. The stimulus therefore drives inputs shortly after the falling edge and reads outputs inside the low phase. The one-hot gated-clock check is sampled on the falling edge, so it sees the high-phase pulses.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  typedef enum logic {
    STORE_FLOP  = 1'b0,
    STORE_LATCH = 1'b1
  } storeStyle_e;

  function automatic int addrBits(input int words);
    return (words > 1) ? $clog2(words) : 1;
  endfunction
endpackage

// File: rtl/rf_icg.sv
`timescale 1ns/1ps
// Latch-based clock gate: enable is captured while clk is low, then ANDed.
module rf_icg (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic enHeld;

  always_latch begin
    if (!clk) enHeld <= en;
  end

  assign gclk = clk & enHeld;
endmodule

// File: rtl/rf_ctrl.sv
`timescale 1ns/1ps
// Write-side control: address decode, per word-slice enable, clock gates.
module rf_ctrl #(
  parameter int NUM_WORDS = 8,
  parameter int NSLICES   = 1,
  parameter int AW        = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [AW-1:0]                wrAddr,
  input  logic [NSLICES-1:0]           wrMask,
  output logic [NUM_WORDS*NSLICES-1:0] sliceClk
);
  logic [NUM_WORDS-1:0] wordSel;
  logic                 wrGo;

  assign wrGo = rstN & wrEn;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    assign wordSel[w] = (wrAddr == AW'(w));
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar s = 0; s < NSLICES; s++) begin : g_slice
      logic sliceEn;
      assign sliceEn = wrGo & wordSel[w] & wrMask[s];
      rf_icg u_icg (
        .clk  (clk),
        .en   (sliceEn),
        .gclk (sliceClk[w*NSLICES+s])
      );
    end
  end
endmodule

// File: rtl/rf_latch.sv
`timescale 1ns/1ps
// Positive-enable transparent latch used for both latch-style stages.
module rf_latch (
  input  logic en,
  input  logic d,
  output logic q
);
  always_latch begin
    if (en) q <= d;
  end
endmodule

// File: rtl/rf_slice.sv
`timescale 1ns/1ps
// One word-slice of storage in the selected style.
module rf_slice #(
  parameter rf_pkg::storeStyle_e STORE_STYLE = rf_pkg::STORE_FLOP,
  parameter int SLICE_BITS = 8
) (
  input  logic                  gclk,
  input  logic [SLICE_BITS-1:0] d,
  output logic [SLICE_BITS-1:0] q
);
  if (STORE_STYLE == rf_pkg::STORE_LATCH) begin : g_latch
    logic                  gclkInv;
    logic [SLICE_BITS-1:0] frontQ;

    // single inverter shared by every bit of this slice
    assign gclkInv = ~gclk;

    for (genvar b = 0; b < SLICE_BITS; b++) begin : g_bit
      rf_latch u_front (
        .en (gclkInv),
        .d  (d[b]),
        .q  (frontQ[b])
      );
      rf_latch u_back (
        .en (gclk),
        .d  (frontQ[b]),
        .q  (q[b])
      );
    end
  end else begin : g_flop
    always_ff @(posedge gclk) begin
      q <= d;
    end
  end
endmodule

// File: rtl/rf_datapath.sv
`timescale 1ns/1ps
// Storage array and read-port selection.
module rf_datapath #(
  parameter rf_pkg::storeStyle_e STORE_STYLE = rf_pkg::STORE_FLOP,
  parameter int NUM_WORDS  = 8,
  parameter int WORD_BITS  = 8,
  parameter int SLICE_BITS = 8,
  parameter int READ_PORTS = 1,
  parameter int AW         = 3
) (
  input  logic [NUM_WORDS*(WORD_BITS/SLICE_BITS)-1:0] sliceClk,
  input  logic [WORD_BITS-1:0]                        wrData,
  input  logic [READ_PORTS*AW-1:0]                    rdAddr,
  output logic [READ_PORTS*WORD_BITS-1:0]             rdData
);
  localparam int NSLICES = WORD_BITS / SLICE_BITS;

  logic [NUM_WORDS*WORD_BITS-1:0] memQ;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar s = 0; s < NSLICES; s++) begin : g_slice
      rf_slice #(
        .STORE_STYLE (STORE_STYLE),
        .SLICE_BITS  (SLICE_BITS)
      ) u_slice (
        .gclk (sliceClk[w*NSLICES+s]),
        .d    (wrData[s*SLICE_BITS +: SLICE_BITS]),
        .q    (memQ[w*WORD_BITS + s*SLICE_BITS +: SLICE_BITS])
      );
    end
  end

  // one-hot selection stands in for a shared tristate bus per port
  for (genvar p = 0; p < READ_PORTS; p++) begin : g_port
    logic [WORD_BITS-1:0] portBus;
    always_comb begin
      portBus = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (rdAddr[p*AW +: AW] == AW'(w)) portBus = portBus | memQ[w*WORD_BITS +: WORD_BITS];
      end
    end
    assign rdData[p*WORD_BITS +: WORD_BITS] = portBus;
  end
endmodule

// File: rtl/rf_regfile.sv
`timescale 1ns/1ps
module rf_regfile #(
  parameter rf_pkg::storeStyle_e STORE_STYLE = rf_pkg::STORE_FLOP,
  parameter int NUM_WORDS  = 8,
  parameter int WORD_BITS  = 8,
  parameter int SLICE_BITS = 8,
  parameter int READ_PORTS = 1,
  parameter int AW         = rf_pkg::addrBits(NUM_WORDS),
  parameter int NSLICES    = WORD_BITS / SLICE_BITS
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [AW-1:0]                   wrAddr,
  input  logic [NSLICES-1:0]              wrMask,
  input  logic [WORD_BITS-1:0]            wrData,
  input  logic [READ_PORTS*AW-1:0]        rdAddr,
  output logic [READ_PORTS*WORD_BITS-1:0] rdData
);
  logic [NUM_WORDS*NSLICES-1:0] sliceClk;

  rf_ctrl #(
    .NUM_WORDS (NUM_WORDS),
    .NSLICES   (NSLICES),
    .AW        (AW)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrMask   (wrMask),
    .sliceClk (sliceClk)
  );

  rf_datapath #(
    .STORE_STYLE (STORE_STYLE),
    .NUM_WORDS   (NUM_WORDS),
    .WORD_BITS   (WORD_BITS),
    .SLICE_BITS  (SLICE_BITS),
    .READ_PORTS  (READ_PORTS),
    .AW          (AW)
  ) u_dp (
    .sliceClk (sliceClk),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );
endmodule

// File: rtl/rf_regfile_chk.sv
`timescale 1ns/1ps
module rf_regfile_chk #(
  parameter int NUM_WORDS  = 8,
  parameter int WORD_BITS  = 8,
  parameter int SLICE_BITS = 8,
  parameter int READ_PORTS = 1,
  parameter int AW         = 3,
  parameter int NSLICES    = 1
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            wrEn,
  input logic [AW-1:0]                   wrAddr,
  input logic [NSLICES-1:0]              wrMask,
  input logic [WORD_BITS-1:0]            wrData,
  input logic [READ_PORTS*AW-1:0]        rdAddr,
  input logic [READ_PORTS*WORD_BITS-1:0] rdData,
  input logic [NUM_WORDS*NSLICES-1:0]    sliceClk
);
  logic [AW-1:0]        rdA0;
  logic [WORD_BITS-1:0] rdD0;
  assign rdA0 = rdAddr[AW-1:0];
  assign rdD0 = rdData[WORD_BITS-1:0];

  // R2: full-mask write is seen on port 0 after the edge
  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (&wrMask) && (32'(wrAddr) < NUM_WORDS))
      |=> ((rdA0 != $past(wrAddr)) || (rdD0 == $past(wrData))));

  // R3: a masked-off slice keeps its value
  p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrMask[0] && (rdA0 == wrAddr))
      |=> ((rdA0 != $past(rdA0)) ||
           (rdD0[SLICE_BITS-1:0] == $past(rdD0[SLICE_BITS-1:0]))));

  // R5: no write request, no change
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |=> ((rdA0 != $past(rdA0)) || (rdD0 == $past(rdD0))));

  // R8: per slice, at most one word's gated clock is high
  for (genvar s = 0; s < NSLICES; s++) begin : g_col
    logic [NUM_WORDS-1:0] col;
    always_comb begin
      for (int w = 0; w < NUM_WORDS; w++) col[w] = sliceClk[w*NSLICES+s];
    end
    p_onehot_clk_r8: assert property (@(negedge clk) disable iff (!rstN)
      $onehot0(col));
  end
endmodule

bind rf_regfile rf_regfile_chk #(
  .NUM_WORDS  (NUM_WORDS),
  .WORD_BITS  (WORD_BITS),
  .SLICE_BITS (SLICE_BITS),
  .READ_PORTS (READ_PORTS),
  .AW         (AW),
  .NSLICES    (NSLICES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrMask   (wrMask),
  .wrData   (wrData),
  .rdAddr   (rdAddr),
  .rdData   (rdData),
  .sliceClk (sliceClk)
);

// File: tb/sim_rf_regfile.sv
`timescale 1ns/1ps
module sim_rf_regfile;
  localparam int NW = 8;
  localparam int WB = 8;
  localparam int SB = 4;
  localparam int RP = 2;
  localparam int AW = 3;
  localparam int NS = WB / SB;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [AW-1:0]   wrAddr = '0;
  logic [NS-1:0]   wrMask = '0;
  logic [WB-1:0]   wrData = '0;
  logic [RP*AW-1:0] rdAddr = '0;
  logic [RP*WB-1:0] rdFlop;
  logic [RP*WB-1:0] rdLatch;

  logic [WB-1:0] refMem [NW];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rf_regfile #(
    .STORE_STYLE (rf_pkg::STORE_FLOP),
    .NUM_WORDS (NW), .WORD_BITS (WB), .SLICE_BITS (SB), .READ_PORTS (RP)
  ) u0 (
    .clk (clk), .rstN (rstN), .wrEn (wrEn), .wrAddr (wrAddr),
    .wrMask (wrMask), .wrData (wrData), .rdAddr (rdAddr), .rdData (rdFlop)
  );

  rf_regfile #(
    .STORE_STYLE (rf_pkg::STORE_LATCH),
    .NUM_WORDS (NW), .WORD_BITS (WB), .SLICE_BITS (SB), .READ_PORTS (RP)
  ) u1 (
    .clk (clk), .rstN (rstN), .wrEn (wrEn), .wrAddr (wrAddr),
    .wrMask (wrMask), .wrData (wrData), .rdAddr (rdAddr), .rdData (rdLatch)
  );

  task automatic chk(input string req, input logic [WB-1:0] act, input logic [WB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // inputs change shortly after the falling edge
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic readCheck(input int port, input int addr, input string req);
    rdAddr[port*AW +: AW] = AW'(addr);
    #0.5;
    chk({req, " flop"},  rdFlop[port*WB +: WB],  refMem[addr]);
    chk({req, " latch"}, rdLatch[port*WB +: WB], refMem[addr]);
    chk("R1 styles agree", rdLatch[port*WB +: WB], rdFlop[port*WB +: WB]);
  endtask

  task automatic writeWord(input int addr, input logic [NS-1:0] mask, input logic [WB-1:0] data);
    step();
    wrEn = 1'b1; wrAddr = AW'(addr); wrMask = mask; wrData = data;
    step();
    wrEn = 1'b0;
    for (int s = 0; s < NS; s++)
      if (mask[s]) refMem[addr][s*SB +: SB] = data[s*SB +: SB];
  endtask

  // R2/R8: back-to-back full writes released together with reset
  task automatic testInit();
    step();
    wrEn = 1'b1; wrMask = '1; wrAddr = '0; wrData = 8'h10;
    rstN = 1'b1;
    for (int w = 0; w < NW; w++) begin
      wrAddr = AW'(w);
      wrData = WB'(8'h3C ^ (w * 8'h17));
      refMem[w] = wrData;
      step();
    end
    wrEn = 1'b0;
    for (int w = 0; w < NW; w++) readCheck(0, w, "R8 distinct words after burst");
    readCheck(1, 2, "R2 full write visible");
  endtask

  task automatic testMask();
    writeWord(3, 2'b01, 8'hA5);
    readCheck(0, 3, "R3 low slice only");
    writeWord(3, 2'b10, 8'h7E);
    readCheck(0, 3, "R3 high slice only");
    writeWord(3, 2'b00, 8'hFF);
    readCheck(0, 3, "R3 empty mask");
  endtask

  task automatic testNeighbours();
    writeWord(5, 2'b11, 8'hC3);
    readCheck(0, 4, "R4 lower neighbour");
    readCheck(0, 6, "R4 upper neighbour");
    readCheck(0, 5, "R2 target word");
  endtask

  task automatic testIdle();
    step();
    wrEn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      wrAddr = AW'(i * 3); wrMask = '1; wrData = WB'(8'h99 + i);
      step();
    end
    for (int w = 0; w < NW; w++) readCheck(0, w, "R5 idle hold");
  endtask

  task automatic testReset();
    step();
    rstN = 1'b0; wrEn = 1'b1; wrMask = '1;
    for (int w = 0; w < NW; w++) begin
      wrAddr = AW'(w); wrData = 8'hEE;
      step();
    end
    wrEn = 1'b0;
    rstN = 1'b1;
    step();
    for (int w = 0; w < NW; w++) readCheck(1, w, "R6 writes blocked in reset");
  endtask

  task automatic testPorts();
    step();
    rdAddr[0 +: AW]  = AW'(1);
    rdAddr[AW +: AW] = AW'(6);
    #0.5;
    chk("R7 port0 flop",  rdFlop[0 +: WB],   refMem[1]);
    chk("R7 port1 flop",  rdFlop[WB +: WB],  refMem[6]);
    chk("R7 port0 latch", rdLatch[0 +: WB],  refMem[1]);
    chk("R7 port1 latch", rdLatch[WB +: WB], refMem[6]);
  endtask

  task automatic testLateData();
    step();
    wrEn = 1'b1; wrAddr = AW'(2); wrMask = '1; wrData = 8'h5A;
    @(posedge clk);
    #1;
    wrData = 8'hA5;
    step();
    wrEn = 1'b0;
    refMem[2] = 8'h5A;
    readCheck(0, 2, "R9 data taken at edge");
  endtask

  task automatic testCombRead();
    step();
    rdAddr[0 +: AW] = AW'(0);
    #0.5;
    chk("R10 first addr flop",  rdFlop[0 +: WB],  refMem[0]);
    rdAddr[0 +: AW] = AW'(7);
    #0.5;
    chk("R10 new addr flop",  rdFlop[0 +: WB],  refMem[7]);
    chk("R10 new addr latch", rdLatch[0 +: WB], refMem[7]);
  endtask

  initial begin
    repeat (3) step();
    testInit();
    testMask();
    testNeighbours();
    testIdle();
    testReset();
    testPorts();
    testLateData();
    testCombRead();
    repeat (2) step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule